// File: doc/BRIEF.md
# Multicycle 16-bit Register Machine Core

This block is a small, non-pipelined processor with a 16-bit word. It completes one instruction before it starts the next. Each instruction passes through a fixed series of control phases: a three-step fetch, decode, an optional address phase, operand read, execute and writeback. All traffic to the internal word-addressed memory goes through a memory address register and a memory data register. A write-enable selects between a read into the data register and a write from the memory-side data path.

The core supports three instructions: a register add, a base-plus-offset load, and a base-plus-offset jump. Any other opcode stops the core until reset. Before a run, a test environment fills the memory through a preload port, which freezes the core while it is active. A debug port shows the program counter, the instruction register, the phase number and the value of any selected general register.

Top module: `cpu_core`

## Requirements
- R1: After reset: PC equals START_PC, IR is 0, all eight 16-bit general registers are 0, the phase is 0 and halt_o is low.
- R2: Fetch uses three phases in order: address (phase 0, MAR takes PC), memory (phase 1, MDR takes the word at MAR), and load (phase 2, IR takes MDR and PC increments by one). Decode is phase 3, address evaluation 4, operand read 5, execute 6, writeback 7 and halt 8.
- R3: Opcode IR[15:12]=4'b0001 adds the register named by IR[8:6] to the register named by IR[2:0] and writes the sum, modulo 2^16, to the register named by IR[11:9]. IR[5:3] has no effect. The address phase is skipped, so the instruction takes 7 cycles.
- R4: Opcode 4'b0110 loads into register IR[11:9] the memory word at the register named by IR[8:6] plus the zero-extended IR[5:0]. The address wraps modulo 2^16. The instruction takes 8 cycles.
- R5: Opcode 4'b1100 loads PC with the register named by IR[8:6] plus the zero-extended IR[5:0], modulo 2^16, on the execute phase. It writes no register and takes 6 cycles.
- R6: Any other opcode moves the core to phase 8 with halt_o high, 4 cycles after that instruction's fetch begins. The core then stays there with PC and registers unchanged until reset.
- R7: While load_en_i is high, memory word load_addr_i takes load_data_i on each clock, and the phase, PC, IR and registers hold their values.
- R8: The memory decodes only the low MEM_AW bits of an address, so addresses 2^MEM_AW apart refer to the same word.
- R9: dbg_reg_o shows, without delay, the general register selected by dbg_reg_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Preload write strobe; freezes the core |
| load_addr_i | input | MEM_AW | Preload word address |
| load_data_i | input | 16 | Preload data word |
| dbg_reg_sel_i | input | 3 | General register to show |
| dbg_reg_o | output | 16 | Value of the selected register |
| dbg_pc_o | output | 16 | Program counter |
| dbg_ir_o | output | 16 | Instruction register |
| dbg_phase_o | output | 4 | Current phase number |
| halt_o | output | 1 | Sticky halt on an illegal opcode |

## Verification
Every instruction takes a fixed number of clock edges: 7 for the add, 8 for the load and 6 for the jump. A halt is reached 4 edges after its fetch begins. The bench releases the preload strobe and then counts edges from that point. It samples 2 ns after the edge on which a result is due, using the running totals of those cycle counts. Some checks fall in the middle of an instruction to show the phase order: the load in phase 4, the add in phase 5 after decode, and the jump still holding the old PC in phase 6. A freeze in the middle of fetch pauses this count; the count resumes when the strobe drops.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int XLEN   = 16;
  localparam int OPC_W  = 4;
  localparam int NUM_OPC = 1 << OPC_W;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OFF_W  = 6;
  localparam int PH_W   = 4;

  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_LDR  = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_JMPR = 4'b1100;

  typedef enum logic [PH_W-1:0] {
    PH_FADDR = 4'd0,
    PH_FMEM  = 4'd1,
    PH_FIR   = 4'd2,
    PH_DEC   = 4'd3,
    PH_ADDR  = 4'd4,
    PH_OPER  = 4'd5,
    PH_EXEC  = 4'd6,
    PH_STORE = 4'd7,
    PH_HALT  = 4'd8
  } phase_e;
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o,
  input  logic [AW-1:0] raddr_d_i,
  output logic [DW-1:0] rdata_d_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))    regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
  assign rdata_d_o = regs[raddr_d_i];
endmodule

// File: rtl/cpu_mem.sv
module cpu_mem #(
  parameter int DW = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
#(
  parameter int OW = OPC_W,
  localparam int NOPC = 1 << OW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            freeze_i,
  input  logic [OW-1:0]   opcode_i,
  output phase_e          phase_o,
  output logic [NOPC-1:0] dec_o,
  output logic            halt_o
);
  phase_e          phase_q, phase_n;
  logic [NOPC-1:0] dec_q, dec_n;
  logic            legal;

  always_comb begin
    dec_n = '0;
    dec_n[opcode_i] = 1'b1;
  end
  assign legal = dec_n[OPC_ADD] | dec_n[OPC_LDR] | dec_n[OPC_JMPR];

  always_comb begin
    phase_n = phase_q;
    unique case (phase_q)
      PH_FADDR: phase_n = PH_FMEM;
      PH_FMEM:  phase_n = PH_FIR;
      PH_FIR:   phase_n = PH_DEC;
      PH_DEC:   phase_n = !legal ? PH_HALT : (dec_n[OPC_LDR] ? PH_ADDR : PH_OPER);
      PH_ADDR:  phase_n = PH_OPER;
      PH_OPER:  phase_n = PH_EXEC;
      PH_EXEC:  phase_n = dec_q[OPC_JMPR] ? PH_FADDR : PH_STORE;
      PH_STORE: phase_n = PH_FADDR;
      PH_HALT:  phase_n = PH_HALT;
      default:  phase_n = PH_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FADDR;
      dec_q   <= '0;
    end else if (!freeze_i) begin
      phase_q <= phase_n;
      if (phase_q == PH_DEC) dec_q <= dec_n;
    end
  end

  assign phase_o = phase_q;
  assign dec_o   = dec_q;
  assign halt_o  = (phase_q == PH_HALT);

  p_halt_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  p_freeze_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(phase_q));
  p_dec_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q inside {PH_ADDR, PH_OPER, PH_EXEC, PH_STORE}) |-> $onehot(dec_q));
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int          MEM_AW   = 8,
  parameter logic [15:0] START_PC = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [15:0]       load_data_i,
  input  logic [2:0]        dbg_reg_sel_i,
  output logic [15:0]       dbg_reg_o,
  output logic [15:0]       dbg_pc_o,
  output logic [15:0]       dbg_ir_o,
  output logic [3:0]        dbg_phase_o,
  output logic              halt_o
);
  phase_e              phase;
  logic [NUM_OPC-1:0]  dec;
  logic [XLEN-1:0]     pc_q, ir_q, mar_q, mdr_q, a_q, b_q, res_q;
  logic [XLEN-1:0]     rs1_data, rs2_data, off_ext;
  logic [XLEN-1:0]     mem_rdata, mem_wdata;
  logic [MEM_AW-1:0]   mem_addr;
  logic                mem_we, rf_we, run;
  logic                unused_bits;

  assign run     = !load_en_i;
  assign off_ext = {{(XLEN-OFF_W){1'b0}}, ir_q[OFF_W-1:0]};

  cpu_ctrl #(.OW(OPC_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .freeze_i (load_en_i),
    .opcode_i (ir_q[15:12]),
    .phase_o  (phase),
    .dec_o    (dec),
    .halt_o   (halt_o)
  );

  // preload owns the memory port; otherwise MAR/MDR with write-enable low
  assign mem_addr  = load_en_i ? load_addr_i : mar_q[MEM_AW-1:0];
  assign mem_wdata = load_en_i ? load_data_i : mdr_q;
  assign mem_we    = load_en_i;

  cpu_mem #(.DW(XLEN), .AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  assign rf_we = run && (phase == PH_STORE);

  cpu_regfile #(.DW(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (ir_q[11:9]),
    .wdata_i   (res_q),
    .raddr_a_i (ir_q[8:6]),
    .rdata_a_o (rs1_data),
    .raddr_b_i (ir_q[2:0]),
    .rdata_b_o (rs2_data),
    .raddr_d_i (dbg_reg_sel_i),
    .rdata_d_o (dbg_reg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= START_PC;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else if (run) begin
      unique case (phase)
        PH_FADDR: mar_q <= pc_q;
        PH_FMEM:  mdr_q <= mem_rdata;
        PH_FIR: begin
          ir_q <= mdr_q;
          pc_q <= pc_q + 16'd1;
        end
        PH_ADDR:  mar_q <= rs1_data + off_ext;
        PH_OPER: begin
          a_q <= rs1_data;
          b_q <= rs2_data;
          if (dec[OPC_LDR]) mdr_q <= mem_rdata;
        end
        PH_EXEC: begin
          if (dec[OPC_ADD])  res_q <= a_q + b_q;
          if (dec[OPC_LDR])  res_q <= mdr_q;
          if (dec[OPC_JMPR]) pc_q  <= a_q + off_ext;
        end
        default: ;
      endcase
    end
  end

  assign dbg_pc_o    = pc_q;
  assign dbg_ir_o    = ir_q;
  assign dbg_phase_o = phase;

  assign unused_bits = ^{mar_q[XLEN-1:MEM_AW], ir_q[5:3], dec};

  p_fetch_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FIR && run) |=> (pc_q == $past(pc_q) + 16'd1));
  p_add_skip_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DEC && run && ir_q[15:12] == OPC_ADD) |=> (phase == PH_OPER));
  p_jmpr_refetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_EXEC && run && ir_q[15:12] == OPC_JMPR) |=> (phase == PH_FADDR));
  p_halt_pc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(pc_q));
  p_freeze_pc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> ($stable(pc_q) && $stable(ir_q)));
endmodule

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
  localparam int MEM_AW = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_en = 1'b1;
  logic [MEM_AW-1:0] load_addr = '0;
  logic [15:0]       load_data = '0;
  logic [2:0]        reg_sel = '0;
  logic [15:0]       reg_val, pc, ir;
  logic [3:0]        phase;
  logic              halt;
  int                vectors = 0;
  int                errors = 0;
  bit                done = 0;

  always #4 clk = ~clk;

  cpu_core #(.MEM_AW(MEM_AW), .START_PC(16'h0000)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .dbg_reg_sel_i(reg_sel), .dbg_reg_o(reg_val),
    .dbg_pc_o(pc), .dbg_ir_o(ir), .dbg_phase_o(phase), .halt_o(halt));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] idx, input logic [15:0] exp);
    reg_sel = idx;
    #1;
    chk(tag, reg_val, exp);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    load_en = 1'b1;
    rst_ni  = 1'b0;
    run(2);
    rst_ni  = 1'b1;
  endtask

  task automatic put(input logic [MEM_AW-1:0] a, input logic [15:0] d);
    load_en = 1'b1; load_addr = a; load_data = d;
    run(1);
  endtask

  task automatic go();
    load_en = 1'b0;
  endtask

  // program: two loads, add, jump, add, illegal opcode
  task automatic t_basic();
    do_reset();
    chk("R1 pc", pc, 16'h0000);
    chk("R1 ir", ir, 16'h0000);
    chk("R1 phase", {12'h0, phase}, 16'h0000);
    chk("R1 halt", {15'h0, halt}, 16'h0000);
    for (int i = 0; i < 8; i++) chk_reg("R1 reg", 3'(i), 16'h0000);
    put(8'd0, 16'h6214); put(8'd1, 16'h6415); put(8'd2, 16'h167A);
    put(8'd3, 16'hC008); put(8'd8, 16'h18C3); put(8'd9, 16'hF000);
    put(8'd20, 16'h1234); put(8'd21, 16'hF00F);
    go();
    run(4);  chk("R4 addr phase", {12'h0, phase}, 16'd4);
    run(4);  chk("R2 pc incr", pc, 16'h0001);
             chk("R2 phase back to fetch", {12'h0, phase}, 16'd0);
             chk_reg("R4 ldr R1", 3'd1, 16'h1234);
    run(8);  chk_reg("R4 ldr R2", 3'd2, 16'hF00F);
    run(4);  chk("R3 add skips addr phase", {12'h0, phase}, 16'd5);
    run(3);  chk_reg("R3 add wrap", 3'd3, 16'h0243);
             chk("R3 pc", pc, 16'h0003);
    run(5);  chk("R5 exec phase", {12'h0, phase}, 16'd6);
             chk("R5 pc before execute", pc, 16'h0004);
    run(1);  chk("R5 pc jumped", pc, 16'h0008);
             chk_reg("R5 no reg write", 3'd0, 16'h0000);
    run(7);  chk_reg("R3 add", 3'd4, 16'h0486);
    run(4);  chk("R6 halt", {15'h0, halt}, 16'h0001);
             chk("R6 halt phase", {12'h0, phase}, 16'd8);
             chk("R6 halt ir", ir, 16'hF000);
             chk("R6 halt pc", pc, 16'h000A);
    run(20); chk("R6 sticky", {15'h0, halt}, 16'h0001);
             chk("R6 pc held", pc, 16'h000A);
             chk_reg("R9 reg held", 3'd4, 16'h0486);
  endtask

  // zero-extended offset, address wrap, jump wrap
  task automatic t_wrap();
    do_reset();
    chk("R1 halt cleared", {15'h0, halt}, 16'h0000);
    chk_reg("R1 reg cleared", 3'd4, 16'h0000);
    put(8'd0, 16'h623F); put(8'd1, 16'h6452); put(8'd2, 16'hC060);
    put(8'h10, 16'h1EA9); put(8'h11, 16'h0000); put(8'd63, 16'hFFF0);
    go();
    run(8);  chk_reg("R4 zero-extended offset", 3'd1, 16'hFFF0);
    run(8);  chk_reg("R4 address wrap", 3'd2, 16'hC060);
    run(6);  chk("R5 jump wrap", pc, 16'h0010);
    run(7);  chk_reg("R3 ignored bits and wrap", 3'd7, 16'hC050);
    run(4);  chk("R6 opcode 0 halts", {15'h0, halt}, 16'h0001);
             chk("R6 pc", pc, 16'h0012);
  endtask

  // preload freeze mid-fetch, memory aliasing
  task automatic t_freeze();
    do_reset();
    put(8'd0, 16'h1200); put(8'd1, 16'h6C32); put(8'd2, 16'hC180);
    put(8'd50, 16'h0110); put(8'h10, 16'hF000);
    go();
    run(2);  chk("R2 fetch phase", {12'h0, phase}, 16'd2);
    load_en = 1'b1; load_addr = 8'd60; load_data = 16'h5555;
    run(5);  chk("R7 phase frozen", {12'h0, phase}, 16'd2);
             chk("R7 pc frozen", pc, 16'h0000);
             chk("R7 ir frozen", ir, 16'h0000);
    go();
    run(5);  chk("R7 resume", pc, 16'h0001);
             chk("R7 resume phase", {12'h0, phase}, 16'd0);
    run(8);  chk_reg("R4 load", 3'd6, 16'h0110);
    run(6);  chk("R5 jump", pc, 16'h0110);
    run(4);  chk("R8 aliased fetch", ir, 16'hF000);
             chk("R8 halt", {15'h0, halt}, 16'h0001);
             chk("R8 pc", pc, 16'h0111);
  endtask

  initial begin
    t_basic();
    t_wrap();
    t_freeze();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule